// File: doc/BRIEF.md
# Cascaded Decade Frequency Divider

This block is a synchronous modulus-1000 counter made from three BCD decade stages that all run on one input clock. The lowest stage advances on every enabled clock. Each higher stage advances only when every stage below it holds 9. The chain therefore counts 000 through 999 in decimal and then returns to 000. Cascading the stages multiplies their moduli: 10 × 10 × 10.

The block does not create any derived clocks. Each stage drives a one-cycle tick that acts as a clock-enable pulse for downstream logic. The ticks fire once every 10, 100 and 1000 enabled input clocks, so a 1 MHz enabled input gives enable rates of 100 kHz, 10 kHz and 1 kHz. The three digit values are also brought out so that the count can be shown or compared. The number of stages, the radix and the structure of the carry network are parameters.

Top module: `decade_divider`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all digits to 0. While the digits are all 0, every tick is low.
- R2: While `en` is low, no digit changes and every tick is low.
- R3: Stage 0 (bits [3:0] of `digit`) counts in BCD 0,1,...,9 and then back to 0. It advances by one on every clock edge where `en` is high, and its value never exceeds 9.
- R4: Stage n (bits [4n+3:4n] of `digit`) advances, wrapping from 9 to 0, only on an edge where `en` is high and every lower stage holds 9. On all other edges it holds its value.
- R5: `tick[n]` is high exactly when `en` is high and stages 0 through n all hold 9. With `en` held high, a tick is never high for two cycles in a row.
- R6: Between resets, successive pulses of `tick[0]`, `tick[1]` and `tick[2]` are separated by exactly 10, 100 and 1000 enabled clocks.
- R7: Starting from all zeros, 1000 enabled clocks bring the three digits back to 000. An edge on which `tick[2]` is high leaves every digit at 0.
- R8: Reset takes priority over `en`: a reset edge with `en` high still leaves all digits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; one enabled clock is one input event |
| digit | output | 12 | BCD digits; stage n at bits [4n+3:4n], stage 0 least significant |
| tick | output | 3 | Per-stage clock-enable pulse; `tick[n]` marks the divide-by-10^(n+1) point |

## Verification
The assertions assume that `rst` is held high through the first clock edge. Before that edge the digit registers carry no defined value, and every clocked property is disabled while reset is high. The assertions also assume that `en` is a clean synchronous level that settles between edges. The bench meets both assumptions by raising reset at time zero and by changing `rst` and `en` only on the falling clock edge. Counting, idle stretches, a reset that arrives while `en` is high, and a full 1000-count wrap are all driven within these limits.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;

   // Structure of the enable network that feeds the stages.
   typedef enum logic {
      CARRY_CHAIN    = 1'b0,   // each stage enable built from the one below
      CARRY_PARALLEL = 1'b1    // each stage enable is one wide AND
   } carry_style_e;

   function automatic int digit_width(input int radix);
      return (radix < 2) ? 1 : $clog2(radix);
   endfunction

endpackage

// File: rtl/decdiv_digit.sv
module decdiv_digit #(
   parameter int RADIX = 10,
   parameter int W     = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   output logic [W-1:0] value,
   output logic         term
);

   localparam logic [W-1:0] LAST = W'(RADIX - 1);

   if (RADIX < 2) begin : g_bad_radix
      $error("decdiv_digit: RADIX must be at least 2");
   end
   if ((1 << W) < RADIX) begin : g_bad_width
      $error("decdiv_digit: W too narrow for RADIX");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         value <= '0;
      end else if (step) begin
         if (value == LAST) value <= '0;
         else               value <= value + 1'b1;
      end
   end

   assign term = (value == LAST);

   AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
      value <= LAST);                                              // R3
   AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (step && value == LAST) |=> (value == '0));                  // R3
   AST_DIGIT_INC: assert property (@(posedge clk) disable iff (rst)
      (step && value != LAST) |=> (value == W'($past(value) + 1'b1))); // R4
   AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(value));                                   // R4

endmodule

// File: rtl/decdiv_carry.sv
module decdiv_carry
   import decdiv_pkg::*;
#(
   parameter int           STAGES = 3,
   parameter carry_style_e STYLE  = CARRY_PARALLEL
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [STAGES-1:0] tc,
   output logic [STAGES-1:0] step,
   output logic [STAGES-1:0] tick
);

   if (STAGES < 1) begin : g_bad_stages
      $error("decdiv_carry: STAGES must be at least 1");
   end

   if (STYLE == CARRY_CHAIN) begin : g_chain
      assign step[0] = en;
      for (genvar n = 1; n < STAGES; n++) begin : g_link
         assign step[n] = step[n-1] & tc[n-1];
      end
   end else begin : g_parallel
      for (genvar n = 0; n < STAGES; n++) begin : g_and
         localparam logic [STAGES-1:0] LOWER = STAGES'((64'd1 << n) - 64'd1);
         assign step[n] = en & (&(tc | ~LOWER));
      end
   end

   assign tick = step & tc;

   AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
      !en |-> (step == '0 && tick == '0));                         // R2

   for (genvar n = 0; n < STAGES; n++) begin : g_chk
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
         (tick[n] && en) |=> !tick[n]);                            // R5
      if (n > 0) begin : g_nest
         AST_TICK_NESTED: assert property (@(posedge clk) disable iff (rst)
            tick[n] |-> tick[n-1]);                                // R5
      end
   end

endmodule

// File: rtl/decade_divider.sv
module decade_divider
   import decdiv_pkg::*;
#(
   parameter int           STAGES      = 3,
   parameter int           RADIX       = 10,
   parameter carry_style_e CARRY_STYLE = CARRY_PARALLEL,
   localparam int          DIGIT_W     = digit_width(RADIX)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   output logic [STAGES*DIGIT_W-1:0] digit,
   output logic [STAGES-1:0]         tick
);

   logic [STAGES-1:0] tc;
   logic [STAGES-1:0] step;

   decdiv_carry #(
      .STAGES (STAGES),
      .STYLE  (CARRY_STYLE)
   ) u_carry (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .tc   (tc),
      .step (step),
      .tick (tick)
   );

   for (genvar n = 0; n < STAGES; n++) begin : g_stage
      decdiv_digit #(
         .RADIX (RADIX),
         .W     (DIGIT_W)
      ) u_digit (
         .clk   (clk),
         .rst   (rst),
         .step  (step[n]),
         .value (digit[n*DIGIT_W +: DIGIT_W]),
         .term  (tc[n])
      );
   end

   AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
      tick[STAGES-1] |=> (digit == '0));                           // R7
   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
      (digit == '0) |-> (tick == '0));                             // R1

endmodule

// File: tb/decade_divider_bench.sv
module decade_divider_bench;

   localparam int CLK_HALF = 10;   // 50 MHz

   typedef struct {
      logic        rst;
      logic        en;
      logic [11:0] digits;
      logic [2:0]  ticks;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [11:0] digit;
   logic [2:0]  tick;

   item_t       sb_q[$];
   int          checks = 0;
   int          errors = 0;
   int          model[3] = '{0, 0, 0};
   string       cur_req = "R1";
   bit          finished = 0;

   always #(CLK_HALF) clk = ~clk;

   decade_divider u_decade_divider (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .digit (digit),
      .tick  (tick)
   );

   function automatic logic [11:0] pack_model();
      return {model[2][3:0], model[1][3:0], model[0][3:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Driver: apply inputs for one cycle, push expectation, advance model.
   task automatic drive(input logic r, input logic e);
      item_t it;
      @(negedge clk);
      rst = r;
      en  = e;
      it.rst    = r;
      it.en     = e;
      it.digits = pack_model();
      it.ticks[0] = e && model[0] == 9;
      it.ticks[1] = it.ticks[0] && model[1] == 9;
      it.ticks[2] = it.ticks[1] && model[2] == 9;
      it.req    = cur_req;
      sb_q.push_back(it);
      if (r) begin
         model = '{0, 0, 0};
      end else if (e) begin
         if (model[0] == 9) begin
            model[0] = 0;
            if (model[1] == 9) begin
               model[1] = 0;
               model[2] = (model[2] == 9) ? 0 : model[2] + 1;
            end else model[1] = model[1] + 1;
         end else model[0] = model[0] + 1;
      end
   endtask

   // Monitor: compare outputs against queued expectations, track tick gaps.
   int en_count = 0;
   int last_tick[3] = '{-1, -1, -1};
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, digit, it.digits, "digits");
            check((it.en ? "R5" : "R2"), tick, it.ticks, "ticks");
            for (int n = 0; n < 3; n++) begin
               if (tick[n] === 1'b1) begin
                  if (last_tick[n] >= 0)
                     check("R6", en_count - last_tick[n], (n == 0) ? 10 : (n == 1) ? 100 : 1000,
                           "tick period");
                  last_tick[n] = en_count;
               end
            end
            if (it.rst) begin
               en_count  = 0;
               last_tick = '{-1, -1, -1};
            end else if (it.en) begin
               en_count++;
            end
         end
      end
   end

   initial begin
      logic [7:0] lfsr;
      // R1: reset state
      cur_req = "R1";
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
      @(negedge clk); #3;
      check("R1", digit, 12'h000, "digits after reset");
      check("R1", tick, 3'b000, "ticks after reset");

      // R3: stage 0 counting and wrap
      cur_req = "R3";
      for (int i = 0; i < 25; i++) drive(1'b0, 1'b1);

      // R2: idle hold
      cur_req = "R2";
      for (int i = 0; i < 7; i++) drive(1'b0, 1'b0);
      @(negedge clk); #3;
      check("R2", digit, 12'h025, "digits held while idle");

      // R4: irregular enable pattern exercising carries
      cur_req = "R4";
      lfsr = 8'hA5;
      for (int i = 0; i < 400; i++) begin
         drive(1'b0, lfsr[0] | lfsr[3]);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end

      // R8: reset while enabled
      cur_req = "R8";
      drive(1'b1, 1'b1);
      drive(1'b0, 1'b0);
      @(negedge clk); #3;
      check("R8", digit, 12'h000, "reset overrides enable");

      // R6 / R7: full 1000-count cycle and beyond
      cur_req = "R7";
      for (int i = 0; i < 1000; i++) drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      @(negedge clk); #3;
      check("R7", digit, 12'h000, "wrap after 1000 enabled clocks");
      cur_req = "R6";
      for (int i = 0; i < 1005; i++) drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      repeat (3) @(negedge clk);
      #5;
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(2 * CLK_HALF * 200000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule